// File: doc/BRIEF.md
# Test-Command Sequencer for an Audio Decoder Data Port

This block emits the fixed command byte streams that put an audio decoder into its built-in test modes. A one-cycle tone request, carrying a 3-bit pitch code and a duration in milliseconds, produces a tone-enable group of bytes. A hold of that many millisecond ticks follows, then a tone-exit group. A one-cycle self-test request produces the memory-check group and waits a fixed number of ticks. It then raises a one-cycle request so that other logic reads the decoder's result register.

Each byte goes to a downstream serial shifter through a valid/ready handshake; the shifter handles bit timing and the byte-sync strobe. The decoder's data-request line must be seen high before every byte is offered. Every cycle spent waiting with that line low uses one poll from a budget shared by the whole 8-byte group. If the budget runs out, the operation stops and completes with an error. A free-running 1 ms tick input gives the timebase. Completion is a one-cycle done pulse together with an error flag.

Top module: `testcmd_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, busy, byte_valid, done, read_req and err are all 0.
- R2: A tone request sends, in this order: 0x53, 0xEF, 0x6E, a pitch byte equal to 56 + 9 × tone_code (codes 0..7 give 56..119), then four 0x00 bytes.
- R3: After the last tone-enable byte is accepted, the block counts tone_ms tick pulses and then sends 0x45, 0x78, 0x69, 0x74 and four 0x00 bytes. With tone_ms = 0 there is no hold, so the first exit byte is offered two cycles after the last enable byte is accepted. The final accepted exit byte is followed by done with err = 0.
- R4: A self-test request sends 0x4D, 0xEA, 0x6D, 0x54 and four 0x00 bytes. The block then counts TEST_WAIT_MS tick pulses and raises done and read_req together for one cycle, with err = 0.
- R5: A byte is offered only in the cycle after data_req was sampled high while waiting. byte_valid and byte_data then stay unchanged until byte_ready is sampled high. No byte is offered while idle.
- R6: Each cycle spent waiting for a byte with data_req low uses one poll. The count restarts at 0 at the start of each 8-byte group. The POLL_BUDGET-th such poll in a group ends the operation: done with err = 1, no more bytes and no read_req.
- R7: A request that arrives while busy is ignored. An accepted request raises busy in the next cycle.
- R8: If a tone request and a self-test request arrive in the same idle cycle, the tone operation is served.
- R9: done lasts exactly one cycle, and busy is low in that cycle. err changes only in a done cycle and keeps its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse each millisecond |
| tone_req | input | 1 | Start a tone operation (pulse) |
| tone_code | input | 3 | Pitch code for the tone |
| tone_ms | input | MS_W | Tone hold in milliseconds |
| test_req | input | 1 | Start a memory self-test (pulse) |
| data_req | input | 1 | Decoder ready-for-data line |
| byte_valid | output | 1 | A byte is offered to the shifter |
| byte_data | output | 8 | Byte offered to the shifter |
| byte_ready | input | 1 | Shifter accepts the offered byte |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Result of the last completion (1 = poll budget ran out) |
| read_req | output | 1 | One-cycle request to read the self-test result |

## Verification
The two request inputs can arrive in the same cycle. The bench raises tone_req and test_req together on an idle block, and again while an operation is running. A request can also fall on a cycle where the block is finishing, and the bench places new requests right after a done pulse. A behavioural model keeps a byte queue and counts ticks and polls. It is compared with the design on every clock, so serving the wrong operation shows up as a wrong byte. An accepted stray request shows up as a busy or valid mismatch. Poll budgets are tested with a shifter that stalls and with data_req dropped for a set number of cycles after each byte.

// File: rtl/testcmd_pkg.sv
// Package: shared types and helpers for the test-command sequencer.
// Assumes every command group is exactly GROUP_BYTES long.
package testcmd_pkg;

    localparam int GROUP_BYTES = 8;
    localparam int IDX_W       = $clog2(GROUP_BYTES);

    // Command group currently being streamed
    typedef enum logic [1:0] {
        GRP_TONE_ON  = 2'd0,
        GRP_TONE_OFF = 2'd1,
        GRP_MEMCHK   = 2'd2
    } grp_e;

    // Controller state
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2,
        ST_HOLD = 2'd3
    } st_e;

    // Pitch byte: 56 plus nine steps per code
    function automatic logic [7:0] pitch_byte(input logic [2:0] code);
        return 8'd56 + (8'd9 * {5'd0, code});
    endfunction

endpackage

// File: rtl/testcmd_rom.sv
// Module: testcmd_rom
// Purpose: maps (group, byte index, pitch code) to the command byte.
// Assumes: each group is four head bytes followed by four zero bytes;
//          the tone-enable group replaces its fourth head byte with the pitch.
module testcmd_rom
    import testcmd_pkg::*;
(
    input  grp_e             grp,
    input  logic [IDX_W-1:0] idx,
    input  logic [2:0]       code,
    output logic [7:0]       data
);

    localparam int HEAD = GROUP_BYTES / 2;

    logic [7:0] head_on  [HEAD];
    logic [7:0] head_off [HEAD];
    logic [7:0] head_mem [HEAD];

    // Head bytes per group
    always_comb begin
        head_on[0]  = 8'h53; head_on[1]  = 8'hEF; head_on[2]  = 8'h6E;
        head_on[3]  = pitch_byte(code);
        head_off[0] = 8'h45; head_off[1] = 8'h78; head_off[2] = 8'h69;
        head_off[3] = 8'h74;
        head_mem[0] = 8'h4D; head_mem[1] = 8'hEA; head_mem[2] = 8'h6D;
        head_mem[3] = 8'h54;
    end

    logic             in_tail;
    logic [IDX_W-2:0] hidx;

    assign in_tail = idx[IDX_W-1];
    assign hidx    = idx[IDX_W-2:0];

    // Select the byte for the current position
    always_comb begin
        if (in_tail) begin
            data = 8'h00;
        end else begin
            unique case (grp)
                GRP_TONE_ON:  data = head_on[hidx];
                GRP_TONE_OFF: data = head_off[hidx];
                GRP_MEMCHK:   data = head_mem[hidx];
                default:      data = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/testcmd_poll_budget.sv
// Module: testcmd_poll_budget
// Purpose: counts low data-request polls across one byte group.
// Assumes: reload and poll never coincide; BUDGET >= 1.
module testcmd_poll_budget #(
    parameter int BUDGET = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    input  logic poll,
    output logic exhausted
);

    localparam int PW = $clog2(BUDGET + 1);

    logic [PW-1:0] used_q;

    assign exhausted = poll && (used_q == PW'(BUDGET - 1));

    // Track polls used in the current group
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q <= '0;
        end else if (reload) begin
            used_q <= '0;
        end else if (poll && !exhausted) begin
            used_q <= used_q + PW'(1);
        end
    end

endmodule

// File: rtl/testcmd_ms_timer.sv
// Module: testcmd_ms_timer
// Purpose: counts millisecond ticks down from a loaded value.
// Assumes: a loaded value of 0 behaves like 1 (the caller skips zero holds).
module testcmd_ms_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             active,
    input  logic             tick,
    output logic             expire
);

    logic [CNT_W-1:0] left_q;

    assign expire = active && tick && (left_q <= CNT_W'(1));

    // Load on request, count down on each tick while active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_val;
        end else if (active && tick && (left_q != '0)) begin
            left_q <= left_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/testcmd_ctrl.sv
// Module: testcmd_ctrl
// Purpose: operation controller; picks the group, steps through bytes,
//          gates each byte on data-request, runs holds, reports completion.
// Assumes: requests are single-cycle pulses; tone has priority.
module testcmd_ctrl
    import testcmd_pkg::*;
#(
    parameter int MS_W         = 8,
    parameter int TEST_WAIT_MS = 40,
    parameter int TW           = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tone_req,
    input  logic [2:0]       tone_code,
    input  logic [MS_W-1:0]  tone_ms,
    input  logic             test_req,
    input  logic             data_req,
    input  logic             byte_ready,
    input  logic             exhausted,
    input  logic             expire,
    output grp_e             grp,
    output logic [IDX_W-1:0] idx,
    output logic [2:0]       code,
    output logic             offer,
    output logic             busy,
    output logic             poll,
    output logic             budget_reload,
    output logic             timer_load,
    output logic [TW-1:0]    timer_val,
    output logic             timer_active,
    output logic             done,
    output logic             err,
    output logic             read_req
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_BYTES - 1);

    st_e              st_q,   st_n;
    grp_e             grp_q,  grp_n;
    logic [IDX_W-1:0] idx_q,  idx_n;
    logic [2:0]       code_q, code_n;
    logic [MS_W-1:0]  ms_q,   ms_n;
    logic             err_q,  err_n;
    logic             done_q, done_n;
    logic             rd_q,   rd_n;

    assign grp          = grp_q;
    assign idx          = idx_q;
    assign code         = code_q;
    assign offer        = (st_q == ST_SEND);
    assign busy         = (st_q != ST_IDLE);
    assign poll         = (st_q == ST_WAIT) && !data_req;
    assign timer_active = (st_q == ST_HOLD);
    assign done         = done_q;
    assign err          = err_q;
    assign read_req     = rd_q;

    // Next-state and strobe decode
    always_comb begin
        st_n          = st_q;
        grp_n         = grp_q;
        idx_n         = idx_q;
        code_n        = code_q;
        ms_n          = ms_q;
        err_n         = err_q;
        done_n        = 1'b0;
        rd_n          = 1'b0;
        budget_reload = 1'b0;
        timer_load    = 1'b0;
        timer_val     = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (tone_req) begin
                    st_n          = ST_WAIT;
                    grp_n         = GRP_TONE_ON;
                    idx_n         = '0;
                    code_n        = tone_code;
                    ms_n          = tone_ms;
                    budget_reload = 1'b1;
                end else if (test_req) begin
                    st_n          = ST_WAIT;
                    grp_n         = GRP_MEMCHK;
                    idx_n         = '0;
                    budget_reload = 1'b1;
                end
            end
            ST_WAIT: begin
                if (data_req) begin
                    st_n = ST_SEND;
                end else if (exhausted) begin
                    st_n   = ST_IDLE;
                    done_n = 1'b1;
                    err_n  = 1'b1;
                end
            end
            ST_SEND: begin
                if (byte_ready) begin
                    if (idx_q != LAST_IDX) begin
                        idx_n = idx_q + IDX_W'(1);
                        st_n  = ST_WAIT;
                    end else begin
                        unique case (grp_q)
                            GRP_TONE_ON: begin
                                if (ms_q == '0) begin
                                    grp_n         = GRP_TONE_OFF;
                                    idx_n         = '0;
                                    budget_reload = 1'b1;
                                    st_n          = ST_WAIT;
                                end else begin
                                    timer_load = 1'b1;
                                    timer_val  = TW'(ms_q);
                                    st_n       = ST_HOLD;
                                end
                            end
                            GRP_TONE_OFF: begin
                                st_n   = ST_IDLE;
                                done_n = 1'b1;
                                err_n  = 1'b0;
                            end
                            default: begin
                                timer_load = 1'b1;
                                timer_val  = TW'(TEST_WAIT_MS);
                                st_n       = ST_HOLD;
                            end
                        endcase
                    end
                end
            end
            ST_HOLD: begin
                if (expire) begin
                    if (grp_q == GRP_TONE_ON) begin
                        grp_n         = GRP_TONE_OFF;
                        idx_n         = '0;
                        budget_reload = 1'b1;
                        st_n          = ST_WAIT;
                    end else begin
                        st_n   = ST_IDLE;
                        done_n = 1'b1;
                        rd_n   = 1'b1;
                        err_n  = 1'b0;
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            grp_q  <= GRP_TONE_ON;
            idx_q  <= '0;
            code_q <= '0;
            ms_q   <= '0;
            err_q  <= 1'b0;
            done_q <= 1'b0;
            rd_q   <= 1'b0;
        end else begin
            st_q   <= st_n;
            grp_q  <= grp_n;
            idx_q  <= idx_n;
            code_q <= code_n;
            ms_q   <= ms_n;
            err_q  <= err_n;
            done_q <= done_n;
            rd_q   <= rd_n;
        end
    end

endmodule

// File: rtl/testcmd_seq.sv
// Module: testcmd_seq (top)
// Purpose: streams decoder test-command byte groups to a serial shifter.
// Assumes: tick_ms is a one-cycle pulse; the shifter holds byte_ready as a
//          plain accept qualifier; TEST_WAIT_MS >= 1.
module testcmd_seq
    import testcmd_pkg::*;
#(
    parameter int POLL_BUDGET  = 5000,
    parameter int MS_W         = 8,
    parameter int TEST_WAIT_MS = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_ms,
    input  logic            tone_req,
    input  logic [2:0]      tone_code,
    input  logic [MS_W-1:0] tone_ms,
    input  logic            test_req,
    input  logic            data_req,
    output logic            byte_valid,
    output logic [7:0]      byte_data,
    input  logic            byte_ready,
    output logic            busy,
    output logic            done,
    output logic            err,
    output logic            read_req
);

    localparam int WAIT_W = $clog2(TEST_WAIT_MS + 1);
    localparam int TW     = (MS_W > WAIT_W) ? MS_W : WAIT_W;

    grp_e             grp;
    logic [IDX_W-1:0] idx;
    logic [2:0]       code;
    logic             poll;
    logic             budget_reload;
    logic             exhausted;
    logic             timer_load;
    logic [TW-1:0]    timer_val;
    logic             timer_active;
    logic             expire;

    testcmd_ctrl #(
        .MS_W         (MS_W),
        .TEST_WAIT_MS (TEST_WAIT_MS),
        .TW           (TW)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .tone_req      (tone_req),
        .tone_code     (tone_code),
        .tone_ms       (tone_ms),
        .test_req      (test_req),
        .data_req      (data_req),
        .byte_ready    (byte_ready),
        .exhausted     (exhausted),
        .expire        (expire),
        .grp           (grp),
        .idx           (idx),
        .code          (code),
        .offer         (byte_valid),
        .busy          (busy),
        .poll          (poll),
        .budget_reload (budget_reload),
        .timer_load    (timer_load),
        .timer_val     (timer_val),
        .timer_active  (timer_active),
        .done          (done),
        .err           (err),
        .read_req      (read_req)
    );

    testcmd_rom u_rom (
        .grp  (grp),
        .idx  (idx),
        .code (code),
        .data (byte_data)
    );

    testcmd_poll_budget #(
        .BUDGET (POLL_BUDGET)
    ) u_budget (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload    (budget_reload),
        .poll      (poll),
        .exhausted (exhausted)
    );

    testcmd_ms_timer #(
        .CNT_W (TW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .active   (timer_active),
        .tick     (tick_ms),
        .expire   (expire)
    );

endmodule

// File: rtl/testcmd_seq_checks.sv
// Module: testcmd_seq_checks
// Purpose: port-level protocol properties, bound onto testcmd_seq.
module testcmd_seq_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       tone_req,
    input logic       test_req,
    input logic       data_req,
    input logic       byte_valid,
    input logic [7:0] byte_data,
    input logic       byte_ready,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic       read_req
);

    // R5: an offer starts only after data_req was seen high
    p_offer_after_dreq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_valid) |-> $past(data_req));

    // R5: an unaccepted offer is held unchanged
    p_offer_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data)));

    // R5: nothing offered while idle
    p_quiet_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !byte_valid);

    // R7: an idle request is taken up in the next cycle
    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (tone_req || test_req)) |=> busy);

    // R9: done is one cycle and coincides with idle
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: err moves only with done
    p_err_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err) |-> done);

    // R4 / R6: read request only on a clean completion
    p_rdreq_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        read_req |-> (done && !err));

endmodule

bind testcmd_seq testcmd_seq_checks u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .tone_req   (tone_req),
    .test_req   (test_req),
    .data_req   (data_req),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .byte_ready (byte_ready),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .read_req   (read_req)
);

// File: tb/testcmd_seq_bench.sv
// Bench: behavioural cycle model (byte queue, tick and poll counters)
// compared with testcmd_seq at every falling edge.
module testcmd_seq_bench;

    localparam int BUDGET   = 20;
    localparam int WAITMS   = 40;
    localparam int MSW      = 8;
    localparam int TICK_GAP = 5;
    localparam int WD_LIMIT = 150000;

    localparam int PH_IDLE = 0, PH_WAIT = 1, PH_OFFER = 2, PH_HOLD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic           tick_ms = 1'b0;
    logic           tone_req = 1'b0;
    logic [2:0]     tone_code = '0;
    logic [MSW-1:0] tone_ms = '0;
    logic           test_req = 1'b0;
    logic           data_req = 1'b1;
    logic           byte_ready = 1'b1;
    logic           byte_valid;
    logic [7:0]     byte_data;
    logic           busy, done, err, read_req;

    testcmd_seq #(
        .POLL_BUDGET  (BUDGET),
        .MS_W         (MSW),
        .TEST_WAIT_MS (WAITMS)
    ) u_testcmd_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_ms    (tick_ms),
        .tone_req   (tone_req),
        .tone_code  (tone_code),
        .tone_ms    (tone_ms),
        .test_req   (test_req),
        .data_req   (data_req),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_ready (byte_ready),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .read_req   (read_req)
    );

    int    compared = 0;
    int    mismatched = 0;
    string cur_req = "R1";

    // stimulus knobs set by the scenario process
    int stall_mode = 0;
    int gap_len = 0;
    bit dreq_stuck_low = 1'b0;

    // values shared between the edge processes
    int cyc = 0;
    int gap_left = 0;
    bit hs_flag = 1'b0;

    // model state
    int         ph = PH_IDLE;
    logic [7:0] q[$];
    int         sent = 0;
    int         polls = 0;
    int         left = 0;
    bit         is_tone = 1'b0;
    int         m_ms = 0;
    bit         exp_valid = 1'b0, exp_busy = 1'b0, exp_done = 1'b0;
    bit         exp_rd = 1'b0, exp_err = 1'b0;
    bit         armed = 1'b0;
    int         gap_watch = -1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual=%0h expected=%0h (t=%0t)",
                     req, what, act, exp, $time);
        end
    endtask

    // Input drivers: tick, shifter ready pattern, data_req gaps; watchdog
    always @(posedge clk) begin
        #1;
        cyc++;
        tick_ms <= ((cyc % TICK_GAP) == 0);
        byte_ready <= (stall_mode != 0) ? ((cyc % 3) != 0) : 1'b1;
        if (hs_flag) gap_left = gap_len;
        if (gap_left > 0) begin
            data_req <= 1'b0;
            gap_left--;
        end else begin
            data_req <= !dreq_stuck_low;
        end
        if (cyc > WD_LIMIT) begin
            mismatched++;
            $display("FAIL R9 watchdog: actual=%0d expected=%0d cycles", cyc, WD_LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // Reference model: compare last prediction, then advance on current inputs
    always @(negedge clk) begin
        if (!rst_n) begin
            ph = PH_IDLE; q.delete(); sent = 0; polls = 0;
            exp_valid = 0; exp_busy = 0; exp_done = 0; exp_rd = 0; exp_err = 0;
            hs_flag = 0; gap_watch = -1;
            armed = 1'b1;
        end else if (armed) begin
            check(busy == exp_busy, "R7", "busy", busy, exp_busy);
            check(byte_valid == exp_valid, "R5", "byte_valid", byte_valid, exp_valid);
            check(done == exp_done, "R9", "done", done, exp_done);
            check(read_req == exp_rd, "R4", "read_req", read_req, exp_rd);
            check(err == exp_err, "R6", "err", err, exp_err);
            if (exp_valid && byte_valid && q.size() > 0)
                check(byte_data == q[0], cur_req, "byte_data", byte_data, q[0]);
            // R3: zero-length hold gives the first exit byte two cycles later
            if (gap_watch >= 0) begin
                gap_watch++;
                if (byte_valid) begin
                    check(gap_watch == 2, "R3", "zero-hold gap", gap_watch, 2);
                    gap_watch = -1;
                end
            end
            hs_flag = byte_valid && byte_ready;

            exp_done = 0;
            exp_rd = 0;
            case (ph)
                PH_IDLE: begin
                    if (tone_req) begin
                        // R8: tone wins over a simultaneous self-test
                        is_tone = 1; m_ms = int'(tone_ms);
                        q = '{8'h53, 8'hEF, 8'h6E, 8'(56 + 9 * int'(tone_code)),
                              8'h00, 8'h00, 8'h00, 8'h00,
                              8'h45, 8'h78, 8'h69, 8'h74,
                              8'h00, 8'h00, 8'h00, 8'h00};
                        sent = 0; polls = 0; ph = PH_WAIT;
                    end else if (test_req) begin
                        is_tone = 0;
                        q = '{8'h4D, 8'hEA, 8'h6D, 8'h54,
                              8'h00, 8'h00, 8'h00, 8'h00};
                        sent = 0; polls = 0; ph = PH_WAIT;
                    end
                end
                PH_WAIT: begin
                    if (data_req) begin
                        ph = PH_OFFER;
                    end else begin
                        polls++;
                        if (polls == BUDGET) begin
                            ph = PH_IDLE; exp_done = 1; exp_err = 1; q.delete();
                        end
                    end
                end
                PH_OFFER: begin
                    if (byte_ready) begin
                        void'(q.pop_front());
                        sent++;
                        if (is_tone && sent == 8) begin
                            if (m_ms == 0) begin
                                polls = 0; ph = PH_WAIT; gap_watch = 0;
                            end else begin
                                left = m_ms; ph = PH_HOLD;
                            end
                        end else if (is_tone && sent == 16) begin
                            ph = PH_IDLE; exp_done = 1; exp_err = 0;
                        end else if (!is_tone && sent == 8) begin
                            left = WAITMS; ph = PH_HOLD;
                        end else begin
                            ph = PH_WAIT;
                        end
                    end
                end
                default: begin
                    if (tick_ms) begin
                        left--;
                        if (left == 0) begin
                            if (is_tone) begin
                                polls = 0; ph = PH_WAIT;
                            end else begin
                                ph = PH_IDLE; exp_done = 1; exp_rd = 1; exp_err = 0;
                            end
                        end
                    end
                end
            endcase
            exp_valid = (ph == PH_OFFER);
            exp_busy  = (ph != PH_IDLE);
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (ph != PH_IDLE || busy) @(negedge clk);
    endtask

    task automatic pulse(input bit t, input bit s, input logic [2:0] c, input int ms);
        @(posedge clk); #1;
        tone_req = t; test_req = s; tone_code = c; tone_ms = MSW'(ms);
        @(posedge clk); #1;
        tone_req = 0; test_req = 0;
    endtask

    initial begin
        // R1: outputs quiet while reset is held
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(busy == 0, "R1", "busy in reset", busy, 0);
        check(byte_valid == 0, "R1", "valid in reset", byte_valid, 0);
        check(done == 0 && read_req == 0, "R1", "done/read_req in reset", done | read_req, 0);
        check(err == 0, "R1", "err in reset", err, 0);
        @(posedge clk); #1;
        rst_n = 1;

        // R2, R3: basic tone with a three-tick hold
        cur_req = "R2";
        pulse(1, 0, 3'd5, 3);
        wait_idle();

        // R2: every pitch code, shifter stalling
        stall_mode = 1;
        for (int c = 0; c < 8; c++) begin
            pulse(1, 0, 3'(c), 1);
            wait_idle();
        end
        stall_mode = 0;

        // R3: zero-length hold
        cur_req = "R3";
        pulse(1, 0, 3'd2, 0);
        wait_idle();

        // R4: self-test followed by read request
        cur_req = "R4";
        pulse(0, 1, 3'd0, 0);
        wait_idle();

        // R8: both requests together, tone expected
        cur_req = "R8";
        pulse(1, 1, 3'd7, 2);
        wait_idle();

        // R7: stray requests during a running tone and a running self-test
        cur_req = "R7";
        pulse(1, 0, 3'd1, 10);
        repeat (30) @(posedge clk);
        pulse(0, 1, 3'd4, 0);
        pulse(1, 0, 3'd6, 1);
        wait_idle();
        pulse(0, 1, 3'd0, 0);
        repeat (12) @(posedge clk);
        pulse(1, 1, 3'd3, 5);
        wait_idle();

        // R5, R6: two-cycle gaps per byte fit within the per-group budget
        cur_req = "R6";
        gap_len = 2;
        stall_mode = 1;
        pulse(1, 0, 3'd4, 2);
        wait_idle();
        pulse(0, 1, 3'd0, 0);
        wait_idle();

        // R6: three-cycle gaps exhaust the budget inside the first group
        gap_len = 3;
        pulse(0, 1, 3'd0, 0);
        wait_idle();
        gap_len = 0;
        stall_mode = 0;

        // R9: a clean completion clears the error flag again
        cur_req = "R9";
        pulse(1, 0, 3'd0, 1);
        wait_idle();

        // R6: data_req stuck low aborts after exactly the budget
        cur_req = "R6";
        dreq_stuck_low = 1;
        pulse(1, 0, 3'd3, 4);
        wait_idle();
        dreq_stuck_low = 0;
        pulse(0, 1, 3'd0, 0);
        wait_idle();

        repeat (4) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule